// File: doc/BRIEF.md
# Paged SPI Register Access Master

This block turns register requests from a local port into SPI master frames aimed at a peripheral whose register space is split into pages. A requester presents a page number, a 7-bit register offset, a width flag (one or two data bytes), write data, a bit mask and an operation code. The block then produces the frames needed on the serial pins and returns a done pulse together with right-aligned read data.

The block remembers the page it last selected on the peripheral. When a request targets another page, it first sends a page-change frame, which is a single-byte write to the page-select register at offset 0x01. Only after that frame completes does it update its cached page. A read-modify-write reads the register, merges the new bits under the mask and writes the result back. The port stays busy throughout, so no other request can come in between the read and the write.

The serial side uses SPI mode 0. The serial clock is the system clock divided by the parameter CLK_DIV. Every frame gets its own chip-select window, and there is an idle gap between consecutive frames.

Top module: `paged_spi_master`

## Requirements
- R1: After reset req_ready is 1, spi_cs_n is 1, spi_sclk is 0 and done is 0. The cached page is 0, so a first request to page 0 sends no page-change frame.
- R2: The first byte of each frame is the command byte. Bits 6:0 are the register offset. Bit 7 is 1 for a read frame and 0 for a write frame. req_op encodes 0 = read, 1 = write, 2 = read-modify-write, 3 = read.
- R3: With req_wide = 1 a frame carries two data bytes, for 3 bytes in all. With req_wide = 0 it carries one data byte, for 2 bytes in all. Data is sent most significant byte first, and a one-byte write sends req_wdata[7:0].
- R4: For a two-byte read, rdata holds both received bytes, with the first byte in bits 15:8. For a one-byte read, the byte is in rdata[7:0] and bits 15:8 are 0. For a plain write, rdata is 0.
- R5: When req_page differs from the cached page, a page-change frame goes out before the access frame. It is a 2-byte write frame with command byte 0x01 and the new page number as its data byte, in a chip-select window of its own.
- R6: The cached page takes the new value once the page-change frame ends. Later requests to that page send no page-change frame.
- R7: A read-modify-write sends one read frame and then one write frame whose data is (old & ~mask) | (wdata & mask). No other request is accepted between them. rdata returns the old value.
- R8: A request is taken when req_valid and req_ready are both 1. req_ready stays 0 from then until done, which is a single-cycle pulse. req_ready is 1 again in the done cycle, and chip select is never low while req_ready is 1.
- R9: SPI mode 0 applies. spi_sclk is 0 whenever spi_cs_n is 1, spi_mosi changes only after a falling edge of spi_sclk, and each spi_sclk period lasts CLK_DIV system cycles.
- R10: Between two frames spi_cs_n stays high for at least CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 read-modify-write, 3 read |
| req_page | input | PAGE_W | Target page number |
| req_ofs | input | 7 | Register offset within the page |
| req_wide | input | 1 | 1: two data bytes, 0: one data byte |
| req_wdata | input | 16 | Write data, right-aligned |
| req_mask | input | 16 | Bits replaced by a read-modify-write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Right-aligned read result, valid with done |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
A stale or wrongly updated cached page appears at the ports within the next request. That request either sends a page-change frame it should not, or omits one it needs, so the frame count for the transaction is wrong and the peripheral model writes into the wrong page. A read-modify-write that merges the wrong bits, or a one-byte result with junk above bit 7, shows up in the stored register or in rdata at the done pulse of the same request. A serial-side counter that runs too long or too short breaks the clock period or the chip-select gap within one frame.

// File: rtl/pspi_pkg.sv
package pspi_pkg;

   // Register data on the serial side is at most two bytes wide.
   localparam int DATA_W  = 16;
   localparam int FRAME_W = 24;
   localparam int BITS_W  = 5;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_RMW   = 2'd2,
      OP_READ2 = 2'd3
   } pspi_op_e;

   // Frame image, left-aligned in FRAME_W bits, command byte leading.
   function automatic logic [FRAME_W-1:0] pspi_frame(input logic is_rd,
                                                     input logic [6:0] ofs,
                                                     input logic wide,
                                                     input logic [DATA_W-1:0] d);
      logic [7:0] cmd;
      cmd = {is_rd, ofs};
      return wide ? {cmd, d} : {cmd, d[7:0], 8'h00};
   endfunction

   function automatic logic [BITS_W-1:0] pspi_bits(input logic wide);
      return wide ? BITS_W'(24) : BITS_W'(16);
   endfunction

   function automatic logic [DATA_W-1:0] pspi_merge(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] new_v,
                                                    input logic [DATA_W-1:0] msk);
      return (old_v & ~msk) | (new_v & msk);
   endfunction

endpackage

// File: rtl/pspi_shifter.sv
module pspi_shifter
   import pspi_pkg::*;
#(
   parameter int CLK_DIV = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BITS_W-1:0]   bits,
   input  logic [FRAME_W-1:0]  tx,
   output logic                fin,
   output logic [DATA_W-1:0]   rx,
   output logic                sclk,
   output logic                cs_n,
   output logic                mosi,
   input  logic                miso
);

   localparam int HALF   = CLK_DIV / 2;
   localparam int GCW    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [GCW-1:0] GAP_LAST = GCW'(CLK_DIV - 1);

   typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_e;

   sh_e                st;
   logic [FRAME_W-1:0] sh;
   logic [BITS_W-1:0]  bitc;
   logic [BITS_W-1:0]  nb;
   logic [GCW-1:0]     gcnt;
   logic               run;
   logic               tick;

   assign run  = (st == SH_SHIFT);
   assign mosi = sh[FRAME_W-1];

   // Half-period tick: a divide-by-two needs no counter at all.
   generate
      if (HALF == 1) begin : g_tick_direct
         assign tick = run;
      end else begin : g_tick_count
         localparam int HCW = $clog2(HALF);
         logic [HCW-1:0] hc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     hc <= '0;
            else if (!run)                  hc <= '0;
            else if (hc == HCW'(HALF - 1))  hc <= '0;
            else                            hc <= hc + 1'b1;
         end
         assign tick = run && (hc == HCW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SH_IDLE;
         sh   <= '0;
         bitc <= '0;
         nb   <= '0;
         gcnt <= '0;
         sclk <= 1'b0;
         cs_n <= 1'b1;
         rx   <= '0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            SH_IDLE: begin
               if (start) begin
                  sh   <= tx;
                  nb   <= bits;
                  bitc <= '0;
                  rx   <= '0;
                  cs_n <= 1'b0;
                  st   <= SH_SHIFT;
               end
            end
            SH_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                     rx   <= {rx[DATA_W-2:0], miso};
                  end else begin
                     sclk <= 1'b0;
                     sh   <= {sh[FRAME_W-2:0], 1'b0};
                     if (bitc == nb - 1'b1) begin
                        cs_n <= 1'b1;
                        gcnt <= '0;
                        st   <= SH_GAP;
                     end else begin
                        bitc <= bitc + 1'b1;
                     end
                  end
               end
            end
            SH_GAP: begin
               if (gcnt == GAP_LAST) begin
                  fin <= 1'b1;
                  st  <= SH_IDLE;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pspi_sequencer.sv
module pspi_sequencer
   import pspi_pkg::*;
#(
   parameter int         PAGE_W       = 8,
   parameter logic [6:0] PAGE_SEL_OFS = 7'h01
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_op,
   input  logic [PAGE_W-1:0]   req_page,
   input  logic [6:0]          req_ofs,
   input  logic                req_wide,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W-1:0]   req_mask,
   output logic                done,
   output logic [DATA_W-1:0]   rdata,
   output logic                f_start,
   output logic [FRAME_W-1:0]  f_tx,
   output logic [BITS_W-1:0]   f_bits,
   input  logic                f_fin,
   input  logic [DATA_W-1:0]   f_rx
);

   typedef enum logic [1:0] {SQ_IDLE, SQ_PAGE, SQ_RD, SQ_WR} sq_e;

   sq_e                st;
   logic [PAGE_W-1:0]  cur_page;
   logic [PAGE_W-1:0]  lat_page;
   logic [1:0]         lat_op;
   logic [6:0]         lat_ofs;
   logic               lat_wide;
   logic [DATA_W-1:0]  lat_wdata;
   logic [DATA_W-1:0]  lat_mask;
   logic [DATA_W-1:0]  old_q;

   // The access frame is built from the live request while idle and from
   // the latched copy once a page change has been put in front of it.
   logic [1:0]         sel_op;
   logic [6:0]         sel_ofs;
   logic               sel_wide;
   logic [DATA_W-1:0]  sel_wdata;
   logic               sel_rd;
   logic [FRAME_W-1:0] op_tx;
   logic [DATA_W-1:0]  rd_val;
   logic [DATA_W-1:0]  page_word;

   always_comb begin
      if (st == SQ_IDLE) begin
         sel_op    = req_op;
         sel_ofs   = req_ofs;
         sel_wide  = req_wide;
         sel_wdata = req_wdata;
      end else begin
         sel_op    = lat_op;
         sel_ofs   = lat_ofs;
         sel_wide  = lat_wide;
         sel_wdata = lat_wdata;
      end
      sel_rd    = (sel_op != OP_WRITE);
      op_tx     = pspi_frame(sel_rd, sel_ofs, sel_wide, sel_wdata);
      rd_val    = lat_wide ? f_rx : {8'h00, f_rx[7:0]};
      page_word = {{(DATA_W - PAGE_W){1'b0}}, req_page};
   end

   assign req_ready = (st == SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur_page  <= '0;
         lat_page  <= '0;
         lat_op    <= OP_READ;
         lat_ofs   <= '0;
         lat_wide  <= 1'b0;
         lat_wdata <= '0;
         lat_mask  <= '0;
         old_q     <= '0;
         f_start   <= 1'b0;
         f_tx      <= '0;
         f_bits    <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         f_start <= 1'b0;
         done    <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (req_valid) begin
                  lat_page  <= req_page;
                  lat_op    <= req_op;
                  lat_ofs   <= req_ofs;
                  lat_wide  <= req_wide;
                  lat_wdata <= req_wdata;
                  lat_mask  <= req_mask;
                  f_start   <= 1'b1;
                  if (req_page != cur_page) begin
                     f_tx   <= pspi_frame(1'b0, PAGE_SEL_OFS, 1'b0, page_word);
                     f_bits <= pspi_bits(1'b0);
                     st     <= SQ_PAGE;
                  end else begin
                     f_tx   <= op_tx;
                     f_bits <= pspi_bits(sel_wide);
                     st     <= sel_rd ? SQ_RD : SQ_WR;
                  end
               end
            end
            SQ_PAGE: begin
               if (f_fin) begin
                  cur_page <= lat_page;
                  f_tx     <= op_tx;
                  f_bits   <= pspi_bits(sel_wide);
                  f_start  <= 1'b1;
                  st       <= sel_rd ? SQ_RD : SQ_WR;
               end
            end
            SQ_RD: begin
               if (f_fin) begin
                  if (lat_op == OP_RMW) begin
                     old_q   <= rd_val;
                     f_tx    <= pspi_frame(1'b0, lat_ofs, lat_wide,
                                           pspi_merge(rd_val, lat_wdata, lat_mask));
                     f_bits  <= pspi_bits(lat_wide);
                     f_start <= 1'b1;
                     st      <= SQ_WR;
                  end else begin
                     rdata <= rd_val;
                     done  <= 1'b1;
                     st    <= SQ_IDLE;
                  end
               end
            end
            SQ_WR: begin
               if (f_fin) begin
                  rdata <= (lat_op == OP_RMW) ? old_q : '0;
                  done  <= 1'b1;
                  st    <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/paged_spi_master.sv
module paged_spi_master
   import pspi_pkg::*;
#(
   parameter int         CLK_DIV      = 4,
   parameter int         PAGE_W       = 8,
   parameter logic [6:0] PAGE_SEL_OFS = 7'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [6:0]        req_ofs,
   input  logic              req_wide,
   input  logic [15:0]       req_wdata,
   input  logic [15:0]       req_mask,
   output logic              done,
   output logic [15:0]       rdata,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("PAGE_W must fit the one-byte page-select data field");
      end
   endgenerate

   logic               f_start;
   logic [FRAME_W-1:0] f_tx;
   logic [BITS_W-1:0]  f_bits;
   logic               f_fin;
   logic [DATA_W-1:0]  f_rx;

   pspi_sequencer #(
      .PAGE_W       (PAGE_W),
      .PAGE_SEL_OFS (PAGE_SEL_OFS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_op    (req_op),
      .req_page  (req_page),
      .req_ofs   (req_ofs),
      .req_wide  (req_wide),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .done      (done),
      .rdata     (rdata),
      .f_start   (f_start),
      .f_tx      (f_tx),
      .f_bits    (f_bits),
      .f_fin     (f_fin),
      .f_rx      (f_rx)
   );

   pspi_shifter #(
      .CLK_DIV (CLK_DIV)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (f_start),
      .bits  (f_bits),
      .tx    (f_tx),
      .fin   (f_fin),
      .rx    (f_rx),
      .sclk  (spi_sclk),
      .cs_n  (spi_cs_n),
      .mosi  (spi_mosi),
      .miso  (spi_miso)
   );

endmodule

// File: rtl/pspi_checker.sv
module pspi_checker #(
   parameter int CLK_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic spi_sclk,
   input logic spi_cs_n,
   input logic spi_mosi
);

   localparam int GW = $clog2(CLK_DIV + 1) + 1;

   // Saturating count of cycles with chip select high.
   logic [GW-1:0] gap_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        gap_cnt <= GW'(CLK_DIV);
      else if (!spi_cs_n)                gap_cnt <= '0;
      else if (gap_cnt < GW'(CLK_DIV))   gap_cnt <= gap_cnt + 1'b1;
   end

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   p_no_frame_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> spi_cs_n);

   p_sclk_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   p_mosi_steady_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));

   p_mosi_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && !spi_cs_n) |=> ($stable(spi_mosi) || !spi_sclk));

   p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (gap_cnt >= GW'(CLK_DIV)));

endmodule

bind paged_spi_master pspi_checker #(.CLK_DIV(CLK_DIV)) u_pspi_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .spi_sclk  (spi_sclk),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi)
);

// File: tb/sim_paged_spi_master.sv
`timescale 1ns/1ps
module sim_paged_spi_master;

   localparam int CLK_DIV = 4;
   localparam int WD_CYC  = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [7:0]  req_page = 8'd0;
   logic [6:0]  req_ofs = 7'd0;
   logic        req_wide = 1'b0;
   logic [15:0] req_wdata = 16'd0;
   logic [15:0] req_mask = 16'd0;
   logic        done;
   logic [15:0] rdata;
   logic        spi_sclk;
   logic        spi_cs_n;
   logic        spi_mosi;
   logic        spi_miso;

   always #5 clk = ~clk;

   paged_spi_master #(.CLK_DIV(CLK_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_page(req_page), .req_ofs(req_ofs), .req_wide(req_wide),
      .req_wdata(req_wdata), .req_mask(req_mask), .done(done), .rdata(rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // ---------------- peripheral register content ----------------
   function automatic logic is_wide(input int o);
      return (o % 3) != 0;
   endfunction

   function automatic logic [15:0] seed_val(input int p, input int o);
      logic [15:0] v;
      v = 16'((p * 945 + o * 157) ^ 16'h5a5a);
      return is_wide(o) ? v : {8'h00, v[7:0]};
   endfunction

   // ---------------- peripheral model (single process) ----------------
   bit [15:0] s_mem [4][128];
   bit        s_val [4][128];
   logic      armed = 1'b0;
   logic      p_cs = 1'b1;
   logic      p_sclk = 1'b0;
   logic [23:0] s_in = '0;
   logic [15:0] s_out = '0;
   logic [7:0]  s_cmd = '0;
   logic [7:0]  s_last_cmd = '0;
   logic [7:0]  s_page = '0;
   logic        s_miso = 1'b0;
   int          s_bits = 0;
   int          s_frames = 0;
   int          s_pframes = 0;
   int          s_pererr = 0;
   int          s_gaperr = 0;
   time         t_rise = 0;
   time         t_csup = 0;

   assign spi_miso = s_miso;

   function automatic logic [15:0] slave_get(input int p, input int o);
      return s_val[p][o] ? s_mem[p][o] : seed_val(p, o);
   endfunction

   always @(spi_cs_n or spi_sclk) begin
      if (armed) begin
         if (spi_cs_n === 1'b0 && p_cs === 1'b1) begin
            s_bits = 0;
            s_in   = '0;
            s_miso = 1'b0;
            if (($time - t_csup) < CLK_DIV * 10) s_gaperr++;
         end
         if (spi_cs_n === 1'b0 && spi_sclk === 1'b1 && p_sclk === 1'b0) begin
            if (s_bits > 0 && ($time - t_rise) != CLK_DIV * 10) s_pererr++;
            t_rise = $time;
            s_in   = {s_in[22:0], spi_mosi};
            s_bits++;
            if (s_bits == 8) begin
               s_cmd = s_in[7:0];
               if (s_in[7]) begin
                  s_out = slave_get(int'(s_page[1:0]), int'(s_in[6:0]));
                  if (!is_wide(int'(s_in[6:0]))) s_out = {s_out[7:0], 8'h00};
               end else begin
                  s_out = '0;
               end
            end
         end
         if (spi_cs_n === 1'b0 && spi_sclk === 1'b0 && p_sclk === 1'b1 && s_bits >= 8) begin
            s_miso = s_out[15];
            s_out  = {s_out[14:0], 1'b0};
         end
         if (spi_cs_n === 1'b1 && p_cs === 1'b0) begin
            t_csup = $time;
            s_frames++;
            s_last_cmd = s_cmd;
            if (!s_cmd[7]) begin
               if (s_bits == 16) begin
                  if (s_cmd[6:0] == 7'h01) begin
                     s_page = s_in[7:0];
                     s_pframes++;
                  end else begin
                     s_mem[s_page[1:0]][s_cmd[6:0]] = {8'h00, s_in[7:0]};
                     s_val[s_page[1:0]][s_cmd[6:0]] = 1'b1;
                  end
               end else if (s_bits == 24) begin
                  s_mem[s_page[1:0]][s_cmd[6:0]] = s_in[15:0];
                  s_val[s_page[1:0]][s_cmd[6:0]] = 1'b1;
               end
            end
         end
      end
      p_cs   = spi_cs_n;
      p_sclk = spi_sclk;
   end

   // ---------------- expected-value model ----------------
   bit [15:0] m_mem [4][128];
   bit        m_val [4][128];
   int        m_page = 0;

   function automatic logic [15:0] model_get(input int p, input int o);
      return m_val[p][o] ? m_mem[p][o] : seed_val(p, o);
   endfunction

   // ---------------- reporting ----------------
   int  checks = 0;
   int  failures = 0;
   logic wd_exp = 1'b0;

   task automatic chk(input logic ok, input string what, input logic [31:0] act,
                      input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      wd_exp = 1'b1;
   end

   // ---------------- one request ----------------
   task automatic do_req(input logic [1:0] op, input int pg, input int o,
                         input logic [15:0] wd, input logic [15:0] mk);
      logic        wide;
      logic [15:0] oldv, newv, merged, exp_rd;
      int          exp_pf, exp_fr, f0, pf0;
      logic        is_wr;
      if (wd_exp) return;
      wide   = is_wide(o);
      oldv   = model_get(pg, o);
      merged = (oldv & ~mk) | (wd & mk);
      is_wr  = (op == 2'd1) || (op == 2'd2);
      newv   = (op == 2'd1) ? (wide ? wd : {8'h00, wd[7:0]})
                            : (wide ? merged : {8'h00, merged[7:0]});
      exp_rd = (op == 2'd1) ? 16'h0000 : oldv;
      exp_pf = (pg != m_page) ? 1 : 0;
      exp_fr = exp_pf + ((op == 2'd2) ? 2 : 1);
      f0     = s_frames;
      pf0    = s_pframes;

      while (!req_ready && !wd_exp) @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_page  = 8'(pg);
      req_ofs   = 7'(o);
      req_wide  = wide;
      req_wdata = wd;
      req_mask  = mk;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 ready low after accept", 32'(req_ready), 32'h0);
      while (!done && !wd_exp) @(negedge clk);
      if (wd_exp) return;
      chk(req_ready == 1'b1, "R8 ready back with done", 32'(req_ready), 32'h1);
      if (op == 2'd2)
         chk(rdata == exp_rd, "R7 rmw returns old value", 32'(rdata), 32'(exp_rd));
      else if (op == 2'd1)
         chk(rdata == exp_rd, "R4 write returns zero", 32'(rdata), 32'(exp_rd));
      else
         chk(rdata == exp_rd, "R4 read data aligned", 32'(rdata), 32'(exp_rd));
      chk((s_pframes - pf0) == exp_pf, "R6 page frame only on change",
          32'(s_pframes - pf0), 32'(exp_pf));
      chk((s_frames - f0) == exp_fr, "R5 R7 frame count", 32'(s_frames - f0), 32'(exp_fr));
      chk(s_page == 8'(pg), "R5 peripheral page", 32'(s_page), 32'(pg));
      chk(s_last_cmd == {~is_wr, 7'(o)}, "R2 command byte",
          32'(s_last_cmd), 32'({~is_wr, 7'(o)}));
      if (is_wr)
         chk(slave_get(pg, o) == newv, "R3 R7 stored register",
             32'(slave_get(pg, o)), 32'(newv));
      @(negedge clk);
      chk(done == 1'b0, "R8 done single pulse", 32'(done), 32'h0);
      m_page = pg;
      if (is_wr) begin
         m_mem[pg][o] = newv;
         m_val[pg][o] = 1'b1;
      end
   endtask

   initial begin
      int unsigned sd;
      sd = $urandom(32'h00C0FFEE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      armed = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
      chk(spi_cs_n == 1'b1, "R1 cs high after reset", 32'(spi_cs_n), 32'h1);
      chk(spi_sclk == 1'b0, "R1 sclk low after reset", 32'(spi_sclk), 32'h0);
      chk(done == 1'b0, "R1 no done after reset", 32'(done), 32'h0);

      // Directed corner cases
      do_req(2'd0, 0, 5, 16'h0000, 16'h0000);   // R1: page 0 cached, no page frame
      do_req(2'd0, 0, 6, 16'h0000, 16'h0000);   // R4: narrow read, upper byte zero
      do_req(2'd1, 2, 7, 16'hBEEF, 16'h0000);   // R5: page change inserted
      do_req(2'd0, 2, 7, 16'h0000, 16'h0000);   // R6: same page, no page frame
      do_req(2'd1, 2, 9, 16'h12A5, 16'h0000);   // R3: narrow write keeps low byte
      do_req(2'd2, 2, 7, 16'h1234, 16'h0000);   // R7: empty mask keeps value
      do_req(2'd2, 2, 7, 16'h1234, 16'hFFFF);   // R7: full mask replaces value
      do_req(2'd2, 2, 7, 16'h0A0A, 16'h00F0);   // R7: partial mask
      do_req(2'd2, 1, 12, 16'hFF3C, 16'h0F0F);  // R7 with page change, narrow
      do_req(2'd3, 1, 12, 16'h0000, 16'h0000);  // R2: op 3 reads
      do_req(2'd0, 0, 127, 16'h0000, 16'h0000); // R5: back to page 0

      // Constrained random traffic
      for (int i = 0; i < 150; i++) begin
         do_req(2'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(2, 127)), 16'($urandom), 16'($urandom));
      end

      repeat (4) @(negedge clk);
      chk(s_pererr == 0, "R9 sclk period", 32'(s_pererr), 32'h0);
      chk(s_gaperr == 0, "R10 chip select gap", 32'(s_gaperr), 32'h0);
      if (wd_exp) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule